// File: doc/BRIEF.md
# Timekeeping Divider with Selectable Frequency Output

This block turns a fast reference into the time base of a real-time clock. A strobe input marks every edge of the reference: two strobes per reference period, so 65,536 strobes per second at the default sizes. A binary chain counts these strobes. Its top bit is the internal one-second square wave. The chain gives a one-cycle pulse once per second and a second pulse once per half second. The half-second pulse is the moment at which the supply comparator is sampled.

A frequency output carries either the reference square wave or a 1 Hz square wave, chosen by a select input. An enable input turns this output on and off. The tri-state enable is brought out as a separate port rather than driving a pad.

The serial write path asks for a divider reset. While that request is high, the stages from the 2^FAST_LOG2 Hz level (128 Hz by default) up to 1 Hz are held at zero. The lower stages keep counting, and no seconds carry happens. The 1 Hz output is the internal second delayed by two periods of the 128 Hz stage.

A sticky low-supply flag is set when the comparator reads low on a half-second pulse. It is cleared by the serial side. If a new low reading arrives in the same cycle as a clear, the reading wins.

Top module: `rtc_clkdiv_top`

## Requirements
- R1: While and directly after reset, fout, fout_en, sec_tick, half_tick and lowv_flag are all 0, and the strobe position is zero.
- R2: Each ref_stb advances the strobe position by one, modulo 2^(REF_LOG2+1). sec_tick is high for exactly the one cycle after the strobe that completes a full second, which is the strobe that wraps the position to zero. half_tick is high for the one cycle after every strobe that completes a half second, and this includes the cycle of sec_tick.
- R3: With foe=1 and fsel=0, fout one cycle later equals bit 0 of the strobe position: the reference square wave, which toggles on every strobe.
- R4: With foe=1 and fsel=1, fout one cycle later is 1 when (position - 2^(REF_LOG2-FAST_LOG2+2)) modulo 2^(REF_LOG2+1) is at least 2^REF_LOG2, and 0 otherwise. This is the internal second delayed by two periods of the 2^FAST_LOG2 Hz stage.
- R5: One cycle after foe is 0, fout_en and fout are both 0. One cycle after foe is 1, fout_en is 1.
- R6: While div_clr is high, the upper REF_LOG2-FAST_LOG2... stages, meaning position bits REF_LOG2-FAST_LOG2 and above, are held at zero. The lower REF_LOG2-FAST_LOG2 bits keep counting strobes, and no sec_tick occurs.
- R7: After div_clr falls, the number of strobes up to and including the one that raises the first sec_tick lies in the range (2^(REF_LOG2+1) - 2^(REF_LOG2-FAST_LOG2), 2^(REF_LOG2+1)].
- R8: With fsel=1, foe=1 and a steady strobe, fout is high for between 40 % and 60 % of any one-second window.
- R9: When half_tick is high and vdet_ok is 0 in the same cycle, lowv_flag is 1 in the next cycle. The flag then stays at 1 until it is cleared.
- R10: lowv_clr drives lowv_flag to 0 in the next cycle, unless a low sample as described in R9 occurs in the same cycle. In that case the flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | One pulse per edge of the reference |
| div_clr | input | 1 | Divider reset and carry hold from the serial side |
| fsel | input | 1 | Output select: 1 gives 1 Hz, 0 gives the reference |
| foe | input | 1 | Frequency output enable |
| vdet_ok | input | 1 | Supply comparator, 0 means the supply is low |
| lowv_clr | input | 1 | Clear for the low-supply flag |
| fout | output | 1 | Selected frequency, 0 when disabled |
| fout_en | output | 1 | Tri-state enable for the frequency pad |
| sec_tick | output | 1 | One-cycle pulse per second |
| half_tick | output | 1 | One-cycle pulse per half second |
| lowv_flag | output | 1 | Sticky low-supply flag |

## Verification
The hardest case to reach is the boundary between a long divider-reset hold and the first shortened second. The lower stages keep running during the hold, so the length of that second depends on where they stand when div_clr falls. It can only be observed as the distance to the next sec_tick.

The stimulus covers this with a directed hold of several hundred strobes, followed by a count of strobes until the first pulse. It also places a simultaneous clear and low sample on the exact cycle of a half_tick. Around these directed cases, seeded random strobes, random holds and random select changes are checked cycle by cycle against a position model kept in the bench.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef enum logic {
    FSRC_REF = 1'b0,
    FSRC_SEC = 1'b1
  } fout_src_e;

  // Number of low stages that keep running during a divider reset.
  function automatic int low_stage_count(input int ref_log2, input int fast_log2);
    return ref_log2 - fast_log2;
  endfunction

endpackage

// File: rtl/rdiv_chain.sv
module rdiv_chain #(
  parameter int REF_LOG2  = 15,
  parameter int FAST_LOG2 = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stb,
  input  logic                  hold,
  output logic [REF_LOG2:0]     cnt_o,
  output logic                  sec_o,
  output logic                  half_o
);
  import rtc_div_pkg::*;

  localparam int W  = REF_LOG2 + 1;
  localparam int LO = low_stage_count(REF_LOG2, FAST_LOG2);
  localparam int HI = W - LO;

  logic [LO-1:0] cnt_lo;
  logic [HI-1:0] cnt_hi;
  logic          lo_full;
  logic          carry_ok;

  assign lo_full  = &cnt_lo;
  assign carry_ok = stb && !hold && lo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      sec_o  <= 1'b0;
      half_o <= 1'b0;
    end else begin
      if (stb) cnt_lo <= cnt_lo + 1'b1;
      if (hold)          cnt_hi <= '0;
      else if (carry_ok) cnt_hi <= cnt_hi + 1'b1;
      sec_o  <= carry_ok && (&cnt_hi);
      half_o <= carry_ok && (&cnt_hi[HI-2:0]);
    end
  end

  assign cnt_o = {cnt_hi, cnt_lo};

  // R2: a second boundary is always also a half-second boundary
  p_sec_has_half_r2: assert property (@(posedge clk) disable iff (rst)
    sec_o |-> half_o);
  // R2: the seconds pulse lasts one cycle
  p_sec_single_r2: assert property (@(posedge clk) disable iff (rst)
    sec_o |=> !sec_o);
  // R6: upper stages are zero while the hold is applied
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_hi == '0));
  // R6: low stages keep running on every strobe
  p_lo_runs_r6: assert property (@(posedge clk) disable iff (rst)
    stb |=> (cnt_lo == LO'($past(cnt_lo) + 1'b1)));
  // R6: no seconds pulse follows a held cycle
  p_hold_no_sec_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> !sec_o);

endmodule

// File: rtl/rdiv_fout.sv
module rdiv_fout #(
  parameter int W  = 16,
  parameter int LO = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         fsel,
  input  logic         foe,
  output logic         fout,
  output logic         fout_en
);
  import rtc_div_pkg::*;

  // Two periods of the stage that sits directly above the LO running stages.
  localparam logic [W-1:0] SHIFT = W'(1) << (LO + 2);

  logic [W-1:0] late_pos;
  logic         sel_val;
  fout_src_e    src;

  assign late_pos = cnt - SHIFT;
  assign src      = fsel ? FSRC_SEC : FSRC_REF;

  always_comb begin
    case (src)
      FSRC_SEC: sel_val = late_pos[W-1];
      default:  sel_val = cnt[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fout    <= 1'b0;
      fout_en <= 1'b0;
    end else begin
      fout    <= foe && sel_val;
      fout_en <= foe;
    end
  end

  // R5: a disabled output is quiet and released
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !foe |=> (!fout && !fout_en));
  // R5: enable reaches the pad control one cycle later
  p_en_r5: assert property (@(posedge clk) disable iff (rst)
    foe |=> fout_en);

endmodule

// File: rtl/rdiv_lowv.sv
module rdiv_lowv (
  input  logic clk,
  input  logic rst,
  input  logic half,
  input  logic vdet_ok,
  input  logic clr,
  output logic flag
);
  logic low_seen;
  assign low_seen = half && !vdet_ok;

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (low_seen) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R9: a low sample on the half-second pulse sets the flag
  p_set_r9: assert property (@(posedge clk) disable iff (rst)
    low_seen |=> flag);
  // R9: the flag holds without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R10: a clear without a concurrent low sample empties the flag
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !low_seen) |=> !flag);

endmodule

// File: rtl/rtc_clkdiv_top.sv
module rtc_clkdiv_top #(
  parameter int REF_LOG2  = 15,
  parameter int FAST_LOG2 = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_stb,
  input  logic div_clr,
  input  logic fsel,
  input  logic foe,
  input  logic vdet_ok,
  input  logic lowv_clr,
  output logic fout,
  output logic fout_en,
  output logic sec_tick,
  output logic half_tick,
  output logic lowv_flag
);
  import rtc_div_pkg::*;

  localparam int W  = REF_LOG2 + 1;
  localparam int LO = low_stage_count(REF_LOG2, FAST_LOG2);

  logic [W-1:0] pos;

  rdiv_chain #(.REF_LOG2(REF_LOG2), .FAST_LOG2(FAST_LOG2)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .stb    (ref_stb),
    .hold   (div_clr),
    .cnt_o  (pos),
    .sec_o  (sec_tick),
    .half_o (half_tick)
  );

  rdiv_fout #(.W(W), .LO(LO)) u_fout (
    .clk     (clk),
    .rst     (rst),
    .cnt     (pos),
    .fsel    (fsel),
    .foe     (foe),
    .fout    (fout),
    .fout_en (fout_en)
  );

  rdiv_lowv u_lowv (
    .clk     (clk),
    .rst     (rst),
    .half    (half_tick),
    .vdet_ok (vdet_ok),
    .clr     (lowv_clr),
    .flag    (lowv_flag)
  );

  // R1: outputs leave reset cleared
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!fout && !fout_en && !sec_tick && !half_tick && !lowv_flag));

endmodule

// File: tb/sim_rtc_clkdiv_top.sv
module sim_rtc_clkdiv_top;
  localparam int REF_LOG2  = 8;
  localparam int FAST_LOG2 = 3;
  localparam int PER   = 2 ** (REF_LOG2 + 1);
  localparam int HALF  = PER / 2;
  localparam int LOMOD = 2 ** (REF_LOG2 - FAST_LOG2);
  localparam int SHIFT = 4 * LOMOD;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, ref_stb = 1'b0, div_clr = 1'b0, fsel = 1'b0, foe = 1'b0;
  logic vdet_ok = 1'b1, lowv_clr = 1'b0;
  logic fout, fout_en, sec_tick, half_tick, lowv_flag;

  rtc_clkdiv_top #(.REF_LOG2(REF_LOG2), .FAST_LOG2(FAST_LOG2)) u0 (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .div_clr(div_clr), .fsel(fsel),
    .foe(foe), .vdet_ok(vdet_ok), .lowv_clr(lowv_clr), .fout(fout),
    .fout_en(fout_en), .sec_tick(sec_tick), .half_tick(half_tick),
    .lowv_flag(lowv_flag)
  );

  int nvec = 0, nfail = 0, cyc = 0;
  bit done = 1'b0, run_chk = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // R4: delayed-second level for a given strobe position
  function automatic int onehz(input int p);
    return (((p - SHIFT + PER) % PER) >= HALF) ? 1 : 0;
  endfunction

  // Bench model of the requirements
  int m_pos = 0;
  int m_sec = 0, m_half = 0, m_fout = 0, m_en = 0, m_flag = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_pos <= 0; m_sec <= 0; m_half <= 0; m_fout <= 0; m_en <= 0; m_flag <= 0;
    end else begin
      m_sec  <= (ref_stb && !div_clr && m_pos == PER - 1) ? 1 : 0;
      m_half <= (ref_stb && !div_clr && (m_pos % HALF) == HALF - 1) ? 1 : 0;
      if (div_clr) m_pos <= ((m_pos % LOMOD) + (ref_stb ? 1 : 0)) % LOMOD;
      else if (ref_stb) m_pos <= (m_pos + 1) % PER;
      m_en   <= foe ? 1 : 0;
      m_fout <= !foe ? 0 : (fsel ? onehz(m_pos) : (m_pos % 2));
      if (m_half == 1 && !vdet_ok) m_flag <= 1;
      else if (lowv_clr) m_flag <= 0;
    end
  end

  always @(negedge clk) begin
    if (run_chk && !rst) begin
      chk("R2 sec_tick", int'(sec_tick), m_sec);
      chk("R2 half_tick", int'(half_tick), m_half);
      chk("R5 fout_en", int'(fout_en), m_en);
      chk("R3/R4 fout", int'(fout), m_fout);
      chk("R9/R10 lowv_flag", int'(lowv_flag), m_flag);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic random_phase(input int n);
    int hold_left = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_stb = ($urandom % 4) != 0;
      if ($urandom % 200 == 0) fsel = ~fsel;
      if ($urandom % 250 == 0) foe = ~foe;
      if (hold_left == 0 && $urandom % 300 == 0) hold_left = 1 + ($urandom % 40);
      div_clr = hold_left > 0;
      if (hold_left > 0) hold_left--;
      vdet_ok = ($urandom % 8) != 0;
      lowv_clr = ($urandom % 50) == 0;
    end
  endtask

  initial begin
    int cnt;
    int hi;
    int prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 fout", int'(fout), 0);
    chk("R1 fout_en", int'(fout_en), 0);
    chk("R1 sec_tick", int'(sec_tick), 0);
    chk("R1 half_tick", int'(half_tick), 0);
    chk("R1 lowv_flag", int'(lowv_flag), 0);
    rst = 1'b0;
    run_chk = 1'b1;

    random_phase(8000);

    // R6: long hold, steady strobes, no seconds pulse
    @(negedge clk);
    fsel = 1'b1; foe = 1'b1; ref_stb = 1'b1; div_clr = 1'b1; vdet_ok = 1'b1; lowv_clr = 1'b0;
    cnt = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (sec_tick) cnt++;
    end
    chk("R6 sec_tick count during hold", cnt, 0);

    // R7: first second after release
    div_clr = 1'b0;
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      cnt++;
      if (sec_tick) break;
    end
    chk("R7 first second within bound", int'(cnt > PER - LOMOD && cnt <= PER), 1);

    // R8: duty of the 1 Hz output over one second
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (fout) hi++;
    end
    chk("R8 duty within 40-60%", int'(hi * 10 >= PER * 4 && hi * 10 <= PER * 6), 1);

    // R3: reference output toggles each strobe
    fsel = 1'b0;
    repeat (2) @(negedge clk);
    prev = int'(fout);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R3 reference toggle", int'(fout), 1 - prev);
      prev = int'(fout);
    end

    // R5: disable releases the pad and quiets the output
    foe = 1'b0;
    @(negedge clk);
    chk("R5 fout_en off", int'(fout_en), 0);
    chk("R5 fout quiet", int'(fout), 0);
    foe = 1'b1;
    @(negedge clk);
    chk("R5 fout_en on", int'(fout_en), 1);

    // R10: clear, then clear and low sample together on a half tick
    lowv_clr = 1'b1;
    @(negedge clk);
    lowv_clr = 1'b0;
    chk("R10 clear", int'(lowv_flag), 0);
    for (int i = 0; i < 600; i++) begin
      if (half_tick) break;
      @(negedge clk);
    end
    vdet_ok = 1'b0; lowv_clr = 1'b1;
    @(negedge clk);
    vdet_ok = 1'b1; lowv_clr = 1'b0;
    chk("R10 low sample wins over clear", int'(lowv_flag), 1);
    repeat (5) @(negedge clk);
    chk("R9 flag sticky", int'(lowv_flag), 1);
    lowv_clr = 1'b1;
    @(negedge clk);
    lowv_clr = 1'b0;
    chk("R10 clear after set", int'(lowv_flag), 0);

    random_phase(6000);

    // R1: reset again from an active state
    @(negedge clk);
    rst = 1'b1;
    run_chk = 1'b0;
    @(negedge clk);
    chk("R1 fout after reset", int'(fout), 0);
    chk("R1 lowv_flag after reset", int'(lowv_flag), 0);
    chk("R1 sec_tick after reset", int'(sec_tick), 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule